// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general registers and the status words of a 32-bit processor core whose operating mode decides which physical copy a logical register number refers to. Sixteen logical registers (0 to 15) are visible at a time, but 31 physical words are stored. The fast-interrupt mode has private copies of registers 8 to 14. The normal-interrupt, supervisor, abort and undefined modes each have private copies of registers 13 and 14 only. Every other register is shared. A private copy keeps its value while its mode is not active and shows it again when the mode is re-entered.

Besides the registers, the block holds the current status word, which also carries the mode field that drives the banking. It holds one saved status word for each of the five privileged modes. Two combinational read ports and one clocked write port address the registers by logical number. A force-user input lets a privileged block transfer read the user copies.

Exception entry is handled by a small state machine with three states:
- `ST_IDLE`: normal accesses.
- `ST_SAVE`: the old status is copied into the target mode's saved status, and the return address is written into the target mode's register 14.
- `ST_SWITCH`: the current status takes the target mode and its interrupt masks.

The transitions are:
- `ST_IDLE` to `ST_SAVE` on an accepted request.
- `ST_SAVE` to `ST_SWITCH` unconditionally.
- `ST_SWITCH` to `ST_IDLE` unconditionally.

A software interrupt is an entry whose target is supervisor mode.

Top module: `banked_regfile`

## Requirements
- R1: After reset the status word reads 0x000000D3, which is supervisor mode with both interrupt masks set. Every register reads zero.
- R2: In user mode (mode code 10000) the logical registers 0 to 15 reach 16 user words. A write to a register is visible on a read port from the next cycle.
- R3: In fast-interrupt mode (10001) registers 8 to 14 use private copies. Registers 0 to 7 and register 15 are shared with user mode.
- R4: In normal-interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes, only registers 13 and 14 use a private copy, one pair per mode. All other registers are shared.
- R5: A banked copy keeps its value across mode changes and reads back when its mode is re-entered.
- R6: A mode code outside the six valid codes makes reads and writes use the user copies.
- R7: The saved status port reads and writes the saved word of the current mode when that mode is one of the five privileged modes. In user mode or an invalid mode, a write is ignored and a read returns zero.
- R8: While force-user is high, both read ports return user copies. Writes still go to the current mode's copies.
- R9: An accepted exception entry holds busy high for exactly two cycles. The entry does the following:
  - The target's saved status gets the old status word.
  - The target's register 14 gets the return address.
  - The status takes the target mode with the IRQ mask (bit 7) set and keeps N, Z, C and V.
  - The FIQ mask (bit 6) is set only when the target is fast-interrupt mode; otherwise it keeps its old value.
- R10: An entry request whose target is user mode or an invalid code is ignored. While busy, new requests, register writes, status writes and saved-status writes are all ignored.
- R11: Status words keep only the following fields, and every other bit reads zero:
  - N, Z, C, V in bits 31 to 28.
  - IRQ mask in bit 7.
  - FIQ mask in bit 6.
  - Mode in bits 4 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_a_idx | input | 4 | Logical register for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Logical register for read port B |
| rd_b_data | output | 32 | Read port B data |
| user_bank | input | 1 | Force both read ports to the user copies |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Logical register to write |
| wr_data | input | 32 | Register write data |
| status_we | input | 1 | Current status write enable; this is how the mode is changed |
| status_wdata | input | 32 | Current status write data |
| status_o | output | 32 | Current status word |
| saved_we | input | 1 | Saved status write enable for the current mode |
| saved_wdata | input | 32 | Saved status write data |
| saved_rdata | output | 32 | Saved status word of the current mode |
| exc_req | input | 1 | Exception entry request |
| exc_mode | input | 5 | Target mode of the entry |
| exc_ret | input | 32 | Return address stored into the target's register 14 |
| exc_busy | output | 1 | Entry sequence in progress |

## Verification
The hardest situation to reach is an exception entry whose target bank already holds values, with other traffic arriving in the same cycles. Register, status and saved-status writes are driven while the entry sequence is busy.

The stimulus first fills every bank through ordinary mode changes. It then starts entries from user, supervisor and normal-interrupt modes, and checks that the write attempted during the busy cycles left no trace.

A long random phase follows. It mixes invalid mode codes, force-user reads and entry requests against a behavioural model of the banks, so that entries also land right after status writes.

// File: rtl/bank_pkg.sv
`timescale 1ns/1ps
package bank_pkg;
    localparam int XLEN       = 32;
    localparam int LREGS      = 16;
    localparam int LW         = $clog2(LREGS);
    localparam int FIQ_LO     = 8;
    localparam int FIQ_N      = 7;
    localparam int PAIR_MODES = 4;
    localparam int PAIR_N     = 2;
    localparam int PAIR_LO    = LREGS - 1 - PAIR_N;
    localparam int NPHYS      = LREGS + FIQ_N + PAIR_MODES * PAIR_N;
    localparam int PW         = $clog2(NPHYS);
    localparam int NSAVED     = 1 + PAIR_MODES;
    localparam int SW         = 3;
    localparam logic [SW-1:0] SLOT_NONE = 3'd7;

    localparam logic [4:0] M_USR = 5'b10000;
    localparam logic [4:0] M_FIQ = 5'b10001;
    localparam logic [4:0] M_IRQ = 5'b10010;
    localparam logic [4:0] M_SVC = 5'b10011;
    localparam logic [4:0] M_ABT = 5'b10111;
    localparam logic [4:0] M_UND = 5'b11011;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAVE   = 2'd1,
        ST_SWITCH = 2'd2
    } entry_state_t;

    typedef struct packed {
        logic [3:0] flags;
        logic       irq_off;
        logic       fiq_off;
        logic [4:0] mode;
    } status_t;

    function automatic logic [XLEN-1:0] status_pack(input status_t s);
        return {s.flags, 20'd0, s.irq_off, s.fiq_off, 1'b0, s.mode};
    endfunction

    function automatic status_t status_unpack(input logic [XLEN-1:0] w);
        status_t s;
        s.flags   = w[31:28];
        s.irq_off = w[7];
        s.fiq_off = w[6];
        s.mode    = w[4:0];
        return s;
    endfunction

    // Saved-status slot of a mode; fast interrupt first, then the pair-banked modes.
    function automatic logic [SW-1:0] saved_slot(input logic [4:0] m);
        logic [SW-1:0] k;
        unique case (m)
            M_FIQ:   k = 3'd0;
            M_IRQ:   k = 3'd1;
            M_SVC:   k = 3'd2;
            M_ABT:   k = 3'd3;
            M_UND:   k = 3'd4;
            default: k = SLOT_NONE;
        endcase
        return k;
    endfunction

    // Physical word index: user words 0..15, fast-interrupt words next, then one pair per mode.
    function automatic logic [PW-1:0] phys_of(input logic [4:0] m, input logic [LW-1:0] r);
        logic [PW-1:0] p;
        logic [SW-1:0] k;
        p = PW'(r);
        k = saved_slot(m);
        if (m == M_FIQ) begin
            if (r >= LW'(FIQ_LO) && r < LW'(FIQ_LO + FIQ_N))
                p = PW'(LREGS) + PW'(r) - PW'(FIQ_LO);
        end else if (k != SLOT_NONE) begin
            if (r >= LW'(PAIR_LO) && r < LW'(PAIR_LO + PAIR_N))
                p = PW'(LREGS + FIQ_N) + PW'(PAIR_N) * PW'(k - SW'(1)) + PW'(r) - PW'(PAIR_LO);
        end
        return p;
    endfunction
endpackage

// File: rtl/bank_map.sv
`timescale 1ns/1ps
module bank_map
    import bank_pkg::*;
(
    input  logic [4:0]    mode,
    input  logic          force_user,
    input  logic [LW-1:0] lreg,
    output logic [PW-1:0] preg
);
    always_comb begin
        preg = phys_of(force_user ? M_USR : mode, lreg);
        // R6: every mode code, valid or not, lands inside the physical array
        assert_phys_in_range_R6: assert (int'(preg) < NPHYS);
    end
endmodule

// File: rtl/gpr_array.sv
`timescale 1ns/1ps
module gpr_array
    import bank_pkg::*;
#(
    parameter int NRD = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [PW-1:0]            waddr,
    input  logic [XLEN-1:0]          wdata,
    input  logic [NRD-1:0][PW-1:0]   raddr,
    output logic [NRD-1:0][XLEN-1:0] rdata
);
    logic [XLEN-1:0]  cells [NPHYS];
    logic [NPHYS-1:0] strobe;

    always_comb begin
        for (int i = 0; i < NPHYS; i++) strobe[i] = we && (waddr == PW'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) cells[i] <= '0;
        end else begin
            for (int i = 0; i < NPHYS; i++) if (strobe[i]) cells[i] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = cells[raddr[p]];
    end

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> cells[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/status_bank.sv
`timescale 1ns/1ps
module status_bank
    import bank_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_open,
    input  logic            cur_we,
    input  logic [XLEN-1:0] cur_wdata,
    input  logic            saved_we,
    input  logic [XLEN-1:0] saved_wdata,
    input  logic            save_now,
    input  logic            switch_now,
    input  logic [4:0]      tgt_mode,
    output logic [XLEN-1:0] cur_word,
    output logic [XLEN-1:0] saved_word,
    output logic [4:0]      cur_mode
);
    status_t       cur_q;
    status_t       saved_q [NSAVED];
    logic [SW-1:0] cur_slot;
    logic [SW-1:0] tgt_slot;

    always_comb begin
        cur_slot = saved_slot(cur_q.mode);
        tgt_slot = saved_slot(tgt_mode);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{flags: 4'd0, irq_off: 1'b1, fiq_off: 1'b1, mode: M_SVC};
        end else if (switch_now) begin
            cur_q.mode    <= tgt_mode;
            cur_q.irq_off <= 1'b1;
            if (tgt_mode == M_FIQ) cur_q.fiq_off <= 1'b1;
        end else if (wr_open && cur_we) begin
            cur_q <= status_unpack(cur_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NSAVED; k++) saved_q[k] <= '0;
        end else begin
            for (int k = 0; k < NSAVED; k++) begin
                if (save_now && tgt_slot == SW'(k))
                    saved_q[k] <= cur_q;
                else if (wr_open && saved_we && cur_slot == SW'(k))
                    saved_q[k] <= status_unpack(saved_wdata);
            end
        end
    end

    always_comb begin
        cur_word   = status_pack(cur_q);
        cur_mode   = cur_q.mode;
        saved_word = (cur_slot == SLOT_NONE) ? '0 : status_pack(saved_q[cur_slot]);
    end

    assert_switch_masks_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        switch_now |=> cur_q.irq_off && cur_q.mode == $past(tgt_mode));

    assert_save_copies_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (save_now && tgt_slot != SLOT_NONE) |=> saved_q[$past(tgt_slot)] == $past(cur_q));
endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
module banked_regfile
    import bank_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LW-1:0]   rd_a_idx,
    output logic [XLEN-1:0] rd_a_data,
    input  logic [LW-1:0]   rd_b_idx,
    output logic [XLEN-1:0] rd_b_data,
    input  logic            user_bank,
    input  logic            wr_en,
    input  logic [LW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic            status_we,
    input  logic [XLEN-1:0] status_wdata,
    output logic [XLEN-1:0] status_o,
    input  logic            saved_we,
    input  logic [XLEN-1:0] saved_wdata,
    output logic [XLEN-1:0] saved_rdata,
    input  logic            exc_req,
    input  logic [4:0]      exc_mode,
    input  logic [XLEN-1:0] exc_ret,
    output logic            exc_busy
);
    localparam int NRD = 2;

    entry_state_t state_q, state_d;
    logic [4:0]      tgt_q;
    logic [XLEN-1:0] ret_q;
    logic            idle, saving, switching, accept;
    logic [4:0]      cur_mode;

    logic [NRD-1:0][LW-1:0]   rd_lreg;
    logic [NRD-1:0][PW-1:0]   rd_preg;
    logic [NRD-1:0][XLEN-1:0] rd_word;
    logic [4:0]      wr_mode;
    logic [LW-1:0]   wr_lreg;
    logic [PW-1:0]   wr_preg;
    logic            gpr_we;
    logic [XLEN-1:0] gpr_wdata;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q <= M_USR;
            ret_q <= '0;
        end else if (accept) begin
            tgt_q <= exc_mode;
            ret_q <= exc_ret;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_SAVE;
            ST_SAVE:   state_d = ST_SWITCH;
            ST_SWITCH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State decoded outputs
    always_comb begin
        idle      = (state_q == ST_IDLE);
        saving    = (state_q == ST_SAVE);
        switching = (state_q == ST_SWITCH);
        exc_busy  = !idle;
        accept    = idle && exc_req && (saved_slot(exc_mode) != SLOT_NONE);
    end

    // Write port: ordinary writes while idle, return address while saving
    always_comb begin
        wr_mode   = saving ? tgt_q : cur_mode;
        wr_lreg   = saving ? LW'(PAIR_LO + 1) : wr_idx;
        gpr_we    = saving || (idle && wr_en);
        gpr_wdata = saving ? ret_q : wr_data;
        rd_lreg   = {rd_b_idx, rd_a_idx};
        rd_a_data = rd_word[0];
        rd_b_data = rd_word[1];
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rmap
        bank_map u_rmap (
            .mode       (cur_mode),
            .force_user (user_bank),
            .lreg       (rd_lreg[p]),
            .preg       (rd_preg[p])
        );
    end

    bank_map u_wmap (
        .mode       (wr_mode),
        .force_user (1'b0),
        .lreg       (wr_lreg),
        .preg       (wr_preg)
    );

    gpr_array #(.NRD(NRD)) u_gpr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (gpr_we),
        .waddr (wr_preg),
        .wdata (gpr_wdata),
        .raddr (rd_preg),
        .rdata (rd_word)
    );

    status_bank u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_open     (idle),
        .cur_we      (status_we),
        .cur_wdata   (status_wdata),
        .saved_we    (saved_we),
        .saved_wdata (saved_wdata),
        .save_now    (saving),
        .switch_now  (switching),
        .tgt_mode    (tgt_q),
        .cur_word    (status_o),
        .saved_word  (saved_rdata),
        .cur_mode    (cur_mode)
    );

    assert_save_then_switch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_SAVE |=> state_q == ST_SWITCH);

    assert_busy_two_cycles_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exc_busy) |=> exc_busy);

    assert_reject_unbanked_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && exc_req && saved_slot(exc_mode) == SLOT_NONE) |=> state_q == ST_IDLE);

    assert_status_frozen_while_saving_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_SAVE |=> $stable(status_o));
endmodule

// File: tb/banked_regfile_bench.sv
`timescale 1ns/1ps
module banked_regfile_bench;
    localparam logic [4:0] MU = 5'h10, MF = 5'h11, MI = 5'h12, MS = 5'h13,
                           MA = 5'h17, MN = 5'h1B, MX = 5'h15;
    localparam logic [31:0] KEEP = 32'hF00000DF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic [31:0] rd_a_data, rd_b_data, wr_data, status_wdata, status_o;
    logic [31:0] saved_wdata, saved_rdata, exc_ret;
    logic        user_bank, wr_en, status_we, saved_we, exc_req, exc_busy;
    logic [4:0]  exc_mode;

    banked_regfile u_banked_regfile (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .user_bank(user_bank),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .status_we(status_we), .status_wdata(status_wdata), .status_o(status_o),
        .saved_we(saved_we), .saved_wdata(saved_wdata), .saved_rdata(saved_rdata),
        .exc_req(exc_req), .exc_mode(exc_mode), .exc_ret(exc_ret), .exc_busy(exc_busy)
    );

    int checks = 0;
    int failures = 0;

    // Behavioural model
    logic [31:0] m_usr [16];
    logic [31:0] m_fiq [7];
    logic [31:0] m_p13 [4];
    logic [31:0] m_p14 [4];
    logic [31:0] m_spsr [5];
    logic [31:0] m_cpsr;
    int          m_state;
    logic [4:0]  m_tgt;
    logic [31:0] m_ret;

    function automatic int pk(input logic [4:0] m);
        case (m)
            MI: return 0;
            MS: return 1;
            MA: return 2;
            MN: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic int sk(input logic [4:0] m);
        if (m == MF) return 0;
        if (pk(m) >= 0) return pk(m) + 1;
        return -1;
    endfunction

    function automatic logic [31:0] mread(input logic [4:0] m, input int r);
        if (m == MF && r >= 8 && r <= 14) return m_fiq[r-8];
        if (pk(m) >= 0 && r == 13) return m_p13[pk(m)];
        if (pk(m) >= 0 && r == 14) return m_p14[pk(m)];
        return m_usr[r];
    endfunction

    task automatic mwrite(input logic [4:0] m, input int r, input logic [31:0] d);
        if (m == MF && r >= 8 && r <= 14) m_fiq[r-8] = d;
        else if (pk(m) >= 0 && r == 13) m_p13[pk(m)] = d;
        else if (pk(m) >= 0 && r == 14) m_p14[pk(m)] = d;
        else m_usr[r] = d;
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_usr[i] = '0;
        for (int i = 0; i < 7; i++) m_fiq[i] = '0;
        for (int i = 0; i < 4; i++) begin m_p13[i] = '0; m_p14[i] = '0; end
        for (int i = 0; i < 5; i++) m_spsr[i] = '0;
        m_cpsr = 32'h000000D3;
        m_state = 0;
        m_tgt = MU;
        m_ret = '0;
    endtask

    task automatic model_update();
        logic [4:0] cm;
        case (m_state)
            0: begin
                cm = m_cpsr[4:0];
                if (wr_en) mwrite(cm, int'(wr_idx), wr_data);
                if (saved_we && sk(cm) >= 0) m_spsr[sk(cm)] = saved_wdata & KEEP;
                if (status_we) m_cpsr = status_wdata & KEEP;
                if (exc_req && sk(exc_mode) >= 0) begin
                    m_state = 1; m_tgt = exc_mode; m_ret = exc_ret;
                end
            end
            1: begin
                m_spsr[sk(m_tgt)] = m_cpsr;
                mwrite(m_tgt, 14, m_ret);
                m_state = 2;
            end
            default: begin
                m_cpsr = (m_cpsr & 32'hF0000040) | 32'h80
                       | ((m_tgt == MF) ? 32'h40 : 32'h0) | {27'd0, m_tgt};
                m_state = 0;
            end
        endcase
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        logic [4:0] em;
        int s;
        em = user_bank ? MU : m_cpsr[4:0];
        s = sk(m_cpsr[4:0]);
        check({tag, " rd_a"}, rd_a_data, mread(em, int'(rd_a_idx)));
        check({tag, " rd_b"}, rd_b_data, mread(em, int'(rd_b_idx)));
        check({tag, " status"}, status_o, m_cpsr);
        check({tag, " saved"}, saved_rdata, (s >= 0) ? m_spsr[s] : 32'h0);
        check({tag, " busy"}, {31'd0, exc_busy}, (m_state != 0) ? 32'd1 : 32'd0);
    endtask

    task automatic step(input string tag);
        #5;
        compare_all(tag);
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic peek(input logic [3:0] r, input logic [31:0] exp, input string tag);
        rd_a_idx = r;
        #2;
        check(tag, rd_a_data, exp);
        step(tag);
    endtask

    task automatic wr(input logic [3:0] r, input logic [31:0] d, input string tag);
        wr_en = 1'b1; wr_idx = r; wr_data = d;
        step(tag);
        wr_en = 1'b0;
    endtask

    task automatic setst(input logic [31:0] w, input string tag);
        status_we = 1'b1; status_wdata = w;
        step(tag);
        status_we = 1'b0;
    endtask

    task automatic savw(input logic [31:0] w, input string tag);
        saved_we = 1'b1; saved_wdata = w;
        step(tag);
        saved_we = 1'b0;
    endtask

    task automatic exc(input logic [4:0] m, input logic [31:0] ret, input string tag);
        exc_req = 1'b1; exc_mode = m; exc_ret = ret;
        step(tag);
        exc_req = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [4:0] modes [7];
        modes = '{MU, MF, MI, MS, MA, MN, MX};
        rd_a_idx = 0; rd_b_idx = 0; wr_idx = 0; wr_data = 0; wr_en = 0;
        user_bank = 0; status_we = 0; status_wdata = 0; saved_we = 0; saved_wdata = 0;
        exc_req = 0; exc_mode = MU; exc_ret = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #2 check("R1 status", status_o, 32'h000000D3);
        check("R1 rd", rd_a_data, 32'h0);
        step("R1");

        // supervisor fill of r0..r15
        for (int i = 0; i < 16; i++) wr(4'(i), 32'h100 + i, "R2");
        setst(32'h10, "R2");
        peek(13, 32'h0, "R4 user r13 separate");
        peek(12, 32'h10C, "R2 shared r12");
        peek(15, 32'h10F, "R2 r15");
        wr(13, 32'h200D, "R2");
        wr(14, 32'h200E, "R2");

        setst(32'h11, "R3");
        peek(8, 32'h0, "R3 fiq r8 private");
        peek(7, 32'h107, "R3 r7 shared");
        for (int i = 8; i < 15; i++) wr(4'(i), 32'h300 + i, "R3");
        peek(15, 32'h10F, "R3 r15 shared");

        setst(32'h12, "R4");
        peek(8, 32'h108, "R4 irq r8 shared");
        peek(13, 32'h0, "R4 irq r13 private");
        wr(13, 32'h400D, "R4");
        setst(32'h17, "R4");
        wr(13, 32'h500D, "R4");
        setst(32'h1B, "R4");
        wr(14, 32'h600E, "R4");
        peek(13, 32'h0, "R4 und r13 private");

        setst(32'h13, "R5");
        peek(13, 32'h10D, "R5 svc r13 kept");
        peek(14, 32'h10E, "R5 svc r14 kept");
        setst(32'h11, "R5");
        peek(9, 32'h309, "R5 fiq r9 kept");

        user_bank = 1'b1;
        peek(9, 32'h109, "R8 user r9 via force");
        peek(13, 32'h200D, "R8 user r13 via force");
        wr(9, 32'hAAAA, "R8");
        user_bank = 1'b0;
        peek(9, 32'hAAAA, "R8 write went to fiq copy");
        user_bank = 1'b1;
        peek(9, 32'h109, "R8 user copy untouched");
        user_bank = 1'b0;

        savw(32'hF00000D1, "R7");
        #2 check("R7 fiq saved", saved_rdata, 32'hF00000D1);
        step("R7");
        savw(32'hFFFFFFFF, "R11");
        #2 check("R11 saved mask", saved_rdata, 32'hF00000DF);
        step("R11");

        setst(32'h15, "R6");
        peek(13, 32'h200D, "R6 invalid uses user r13");
        peek(9, 32'h109, "R6 invalid uses user r9");
        #2 check("R7 invalid saved reads zero", saved_rdata, 32'h0);
        step("R7");
        savw(32'h12345678, "R7");
        wr(13, 32'h700D, "R6");
        setst(32'h12, "R7");
        #2 check("R7 irq saved untouched", saved_rdata, 32'h0);
        step("R7");
        setst(32'h10, "R6");
        peek(13, 32'h700D, "R6 invalid write hit user r13");
        #2 check("R7 user saved reads zero", saved_rdata, 32'h0);
        step("R7");

        setst(32'hFFFFFF33, "R11");
        #2 check("R11 status mask", status_o, 32'hF0000013);
        step("R11");

        // exception entry user -> fiq
        setst(32'h80000010, "R9");
        exc(MF, 32'hCAFE0000, "R9");
        #2 check("R9 busy save", {31'd0, exc_busy}, 32'd1);
        wr_en = 1'b1; wr_idx = 0; wr_data = 32'hDEAD;
        status_we = 1'b1; status_wdata = 32'h10;
        saved_we = 1'b1; saved_wdata = 32'h0;
        step("R10");
        wr_en = 1'b0; status_we = 1'b0; saved_we = 1'b0;
        #2 check("R9 busy switch", {31'd0, exc_busy}, 32'd1);
        step("R9");
        #2 check("R9 busy done", {31'd0, exc_busy}, 32'd0);
        check("R9 fiq status", status_o, 32'h800000D1);
        check("R9 fiq saved", saved_rdata, 32'h80000010);
        step("R9");
        peek(14, 32'hCAFE0000, "R9 fiq r14 return");
        peek(0, 32'h100, "R10 write during busy ignored");
        exc(MU, 32'h1, "R10");
        #2 check("R10 user target ignored", {31'd0, exc_busy}, 32'd0);
        step("R10");

        // svc -> irq keeps fiq mask clear
        setst(32'h40000013, "R9");
        exc(MI, 32'h1234, "R9");
        step("R9");
        step("R9");
        #2 check("R9 irq status", status_o, 32'h40000092);
        check("R9 irq saved", saved_rdata, 32'h40000013);
        step("R9");
        peek(14, 32'h1234, "R9 irq r14 return");

        // software interrupt: irq -> svc
        exc(MS, 32'h8, "R9");
        step("R9");
        step("R9");
        #2 check("R9 svc status", status_o, 32'h40000093);
        step("R9");
        peek(14, 32'h8, "R9 svc r14 return");

        // random phase against the model
        for (int n = 0; n < 3000; n++) begin
            rd_a_idx = 4'($urandom);
            rd_b_idx = 4'($urandom);
            user_bank = ($urandom % 4) == 0;
            wr_en = $urandom % 2;
            wr_idx = 4'($urandom);
            wr_data = $urandom;
            status_we = ($urandom % 8) == 0;
            status_wdata = {$urandom} & 32'hFFFFFFE0 | {27'd0, modes[$urandom % 7]};
            saved_we = ($urandom % 6) == 0;
            saved_wdata = $urandom;
            exc_req = ($urandom % 10) == 0;
            exc_mode = modes[$urandom % 7];
            exc_ret = $urandom;
            step("RND R2");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule